// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit

This block is an integer multiplier that takes several clock cycles per operation. It covers two families of operation. The short family returns the low 32 bits of a product, with or without a 32-bit addend. The long family returns the full 64-bit product, signed or unsigned, with or without a 64-bit addend. The caller presents both operands, the addend words and a 3-bit operation code, and pulses `start` while the unit is idle. The unit then raises `busy`. When the answer is ready it pulses `done` for a single cycle, with the result on `res_hi`/`res_lo`.

Inside, a shift-and-add engine consumes the second operand (`opb`, the multiplier) one 8-bit slice per cycle, least significant slice first, and adds each slice's partial product into a 64-bit running sum. It stops as soon as the slices not yet consumed carry no information: they are all zero, or, for signed long operations, they are copies of the sign. A small operand therefore finishes in 2 cycles, and a full-width operand takes 5.

The control is a two-state machine. `ST_IDLE` waits for `start`, and the transition *accept* (start seen in `ST_IDLE`) loads the operands and moves to `ST_RUN`. `ST_RUN` processes one slice per cycle. The transition *step* (slice processed, more remain) stays in `ST_RUN`. The transition *finish* (the slice just processed was the last one needed) writes the result, fires `done` and returns to `ST_IDLE`.

Top module: `mac_iter_unit`

## Requirements
- R1: Operation code 000 returns the low 32 bits of opa*opb. Code 001 returns the low 32 bits of opa*opb + acc_lo. For both, res_hi is 0 and op[1] has no effect (codes 010 and 011 behave as 000 and 001).
- R2: Code 100 returns the 64-bit unsigned product {res_hi,res_lo} = opa*opb. Code 101 returns that product plus {acc_hi,acc_lo}, modulo 2^64.
- R3: Code 110 returns the 64-bit two's-complement product of opa and opb. Code 111 adds the signed product to {acc_hi,acc_lo}, modulo 2^64.
- R4: A start that is high at a clock edge while busy is low is accepted, and busy is high in the following cycle.
- R5: A start that arrives while busy is high is ignored: it produces no extra done pulse and does not change the result of the operation in progress.
- R6: done is high for exactly one cycle, and the result is valid in that cycle. res_hi and res_lo keep their value until the next done. busy and done are never high together.
- R7: The number of slices n lies between 1 and 4. For codes other than 110/111, n is 1 plus the index of the highest nonzero byte of opb, or 1 when opb is 0. busy stays high for n cycles, and done appears n+1 cycles after the accepting edge's cycle, so the latency is 2 to 5 cycles.
- R8: For codes 110/111, n is the smallest k+1 (k = 0..3) such that opb bits 31..8k+8 are all zero, or opb bits 31..8k+7 are all one.
- R9: After reset, busy and done are low and both result words are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| op | input | 3 | Operation code: bit2 long, bit1 signed (long only), bit0 accumulate |
| opa | input | 32 | Multiplicand |
| opb | input | 32 | Multiplier; its width sets the latency |
| acc_hi | input | 32 | Upper addend word (long accumulate only) |
| acc_lo | input | 32 | Lower addend word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 32 | Upper result word (0 for short codes) |
| res_lo | output | 32 | Lower result word |

## Verification
The bench drives multipliers that end early at each slice boundary in both signed and unsigned form. The cases include a negative slice whose top bit absorbs an all-ones tail, and -129, which needs one slice more than -128. A design that mishandled the sign tail would return a product off by a multiple of opa shifted up by 8k, or report the wrong latency. Extreme values are also covered: all-ones operands, the most negative multiplier, and addends that wrap. These expose a lost carry into the upper word or a sign that leaked into unsigned arithmetic. A start held during a busy operation, and a new start in the same cycle as done, would show up as a spurious second result or a missed operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mac_state_e;

    typedef struct packed {
        logic wide;   // 64-bit result
        logic sgn;    // two's-complement operands
        logic accum;  // add the addend
    } mac_ctl_t;

endpackage

// File: rtl/mac_opdec.sv
module mac_opdec
    import mac_pkg::*;
(
    input  logic [2:0] op,
    output mac_ctl_t   ctl
);
    // bit2 selects the long family; signedness only exists there
    always_comb begin
        ctl.wide  = op[2];
        ctl.sgn   = op[2] & op[1];
        ctl.accum = op[0];
    end
endmodule

// File: rtl/mac_digit.sv
module mac_digit #(
    parameter int W     = 32,
    parameter int CHUNK = 8
) (
    input  logic [W-1:0]                 mplier,
    input  logic [$clog2(W/CHUNK)-1:0]   step,
    input  logic                         sgn,
    output logic signed [CHUNK:0]        digit,
    output logic                         last
);
    localparam int STEPS = W / CHUNK;

    logic [STEPS-1:0] upper_zero;  // bits above slice k all zero
    logic [STEPS-1:0] upper_ones;  // slice k msb and everything above all one
    logic [CHUNK-1:0] slice;

    for (genvar k = 0; k < STEPS; k++) begin : g_tail
        if (k == STEPS - 1) begin : g_top
            assign upper_zero[k] = 1'b1;
            assign upper_ones[k] = mplier[W-1];
        end else begin : g_mid
            assign upper_zero[k] = ~|mplier[W-1:(k+1)*CHUNK];
            assign upper_ones[k] = &mplier[W-1:(k+1)*CHUNK-1];
        end
    end

    always_comb begin
        slice = mplier[int'(step)*CHUNK +: CHUNK];
        if (sgn && upper_ones[step]) begin
            // negative tail folded into this slice as a signed digit
            digit = {slice[CHUNK-1], slice};
            last  = 1'b1;
        end else begin
            digit = {1'b0, slice};
            last  = upper_zero[step];
        end
    end
endmodule

// File: rtl/mac_iter_unit.sv
module mac_iter_unit
    import mac_pkg::*;
#(
    parameter int W     = 32,
    parameter int CHUNK = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);
    localparam int RW    = 2 * W;
    localparam int STEPS = W / CHUNK;
    localparam int SW    = $clog2(STEPS);

    mac_state_e state_q, state_nx;
    mac_ctl_t   ctl;

    logic [RW-1:0]         a_ext_q;
    logic [W-1:0]          b_q;
    logic [SW-1:0]         step_q;
    logic [RW-1:0]         sum_q;
    logic                  wide_q;
    logic                  sgn_q;
    logic signed [CHUNK:0] digit;
    logic                  last;
    logic [RW-1:0]         dig_ext;
    logic [RW-1:0]         term;
    logic [RW-1:0]         sum_nx;
    logic                  take;

    mac_opdec u_dec (
        .op  (op),
        .ctl (ctl)
    );

    mac_digit #(.W(W), .CHUNK(CHUNK)) u_digit (
        .mplier (b_q),
        .step   (step_q),
        .sgn    (sgn_q),
        .digit  (digit),
        .last   (last)
    );

    always_comb begin
        dig_ext = RW'(digit);
        term    = a_ext_q * dig_ext;
        sum_nx  = sum_q + (term << (int'(step_q) * CHUNK));
        take    = start && (state_q == ST_IDLE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions: accept, step, finish
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (last)  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        unique case (state_q)
            ST_RUN:  busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_ext_q <= '0;
            b_q     <= '0;
            step_q  <= '0;
            sum_q   <= '0;
            wide_q  <= 1'b0;
            sgn_q   <= 1'b0;
            done    <= 1'b0;
            res_hi  <= '0;
            res_lo  <= '0;
        end else begin
            done <= 1'b0;
            if (take) begin
                a_ext_q <= ctl.sgn ? {{W{opa[W-1]}}, opa} : {{W{1'b0}}, opa};
                b_q     <= opb;
                step_q  <= '0;
                wide_q  <= ctl.wide;
                sgn_q   <= ctl.sgn;
                if (!ctl.accum)   sum_q <= '0;
                else if (ctl.wide) sum_q <= {acc_hi, acc_lo};
                else              sum_q <= {{W{1'b0}}, acc_lo};
            end else if (state_q == ST_RUN) begin
                sum_q  <= sum_nx;
                step_q <= step_q + 1'b1;
                if (last) begin
                    done   <= 1'b1;
                    res_lo <= sum_nx[W-1:0];
                    res_hi <= wide_q ? sum_nx[RW-1:W] : '0;
                end
            end
        end
    end
endmodule

// File: rtl/mac_iter_chk.sv
module mac_iter_chk #(
    parameter int W     = 32,
    parameter int CHUNK = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         op_wide,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] res_hi,
    input logic [W-1:0] res_lo
);
    localparam int STEPS = W / CHUNK;
    localparam int CW    = $clog2(STEPS) + 2;

    logic [CW-1:0] run_q;
    logic          long_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            long_q <= 1'b0;
        end else begin
            run_q <= busy ? run_q + 1'b1 : '0;
            if (start && !busy) long_q <= op_wide;
        end
    end

    assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < CW'(STEPS)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_lo) && $stable(res_hi)));

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_short_high_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !long_q) |-> (res_hi == '0));
endmodule

bind mac_iter_unit mac_iter_chk #(.W(W), .CHUNK(CHUNK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_wide (op[2]),
    .busy    (busy),
    .done    (done),
    .res_hi  (res_hi),
    .res_lo  (res_lo)
);

// File: tb/mac_iter_unit_test.sv
`timescale 1ns/1ps
module mac_iter_unit_test;

    typedef struct {
        logic [63:0] val;
        int          lat;
        int          issue;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opa = '0, opb = '0, acc_hi = '0, acc_lo = '0;
    logic        busy, done;
    logic [31:0] res_hi, res_lo;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   done_prev = 1'b0;
    exp_t q[$];
    logic [63:0] last_val = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mac_iter_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
    );

    function automatic int slices(input logic [2:0] code, input logic [31:0] b);
        for (int k = 0; k < 4; k++) begin
            if ((b >> (8*k + 8)) == 32'd0) return k + 1;
            if (code[2] && code[1] && (($signed(b) >>> (8*k + 7)) == -32'sd1)) return k + 1;
        end
        return 4;
    endfunction

    function automatic logic [63:0] model(input logic [2:0] code, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] h,
                                          input logic [31:0] l);
        logic        s;
        logic [63:0] a64, b64, p;
        s   = code[2] & code[1];
        a64 = s ? {{32{a[31]}}, a} : {32'd0, a};
        b64 = s ? {{32{b[31]}}, b} : {32'd0, b};
        p   = a64 * b64;
        if (code[0]) p = p + (code[2] ? {h, l} : {32'd0, l});
        if (!code[2]) p = {32'd0, p[31:0]};
        return p;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input string tag, input logic [2:0] code, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] h, input logic [31:0] l);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        op = code; opa = a; opb = b; acc_hi = h; acc_lo = l; start = 1'b1;
        e.val = model(code, a, b, h, l);
        e.lat = slices(code, b) + 1;
        e.issue = cyc;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_prev) check("R6 done width", {63'd0, done}, 64'd0);
            if (done) begin
                if (q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R5 unexpected done actual=%h expected=none", {res_hi, res_lo});
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.tag, {res_hi, res_lo}, e.val);
                    check({e.tag, " R7 latency"}, 64'(cyc - e.issue), 64'(e.lat));
                    last_val = e.val;
                end
            end
            done_prev <= done;
        end
    end

    initial begin
        #(5.0 * 20000);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 busy", {63'd0, busy}, 64'd0);
        check("R9 done", {63'd0, done}, 64'd0);
        check("R9 result", {res_hi, res_lo}, 64'd0);
        rst_n = 1'b1;

        // R1 short forms
        issue("R1 mul small", 3'b000, 32'd7, 32'd6, 32'h0, 32'h0);
        issue("R1 mul full", 3'b000, 32'h12345678, 32'h9abcdef0, 32'hffff, 32'h1);
        issue("R1 mla", 3'b001, 32'd1000, 32'h0001_0203, 32'hdead, 32'd100);
        issue("R1 mla wrap", 3'b001, 32'hffffffff, 32'd2, 32'h0, 32'd5);
        issue("R1 op010 as mul", 3'b010, 32'hfffffff0, 32'h0000_8001, 32'h0, 32'h0);
        issue("R1 op011 as mla", 3'b011, 32'h80000000, 32'hffffffff, 32'h0, 32'd3);
        // R2 unsigned long
        issue("R2 umull max", 3'b100, 32'hffffffff, 32'hffffffff, 32'h0, 32'h0);
        issue("R2 umull b7f", 3'b100, 32'h00000003, 32'hffffff7f, 32'h0, 32'h0);
        issue("R2 umlal carry", 3'b101, 32'hffffffff, 32'h00ff_ffff, 32'hffffffff, 32'hffffffff);
        // R3 / R8 signed long, each stop point
        issue("R3 R8 smull m1 m1", 3'b110, 32'hffffffff, 32'hffffffff, 32'h0, 32'h0);
        issue("R3 R8 smull 128", 3'b110, 32'hfffffffb, 32'h00000080, 32'h0, 32'h0);
        issue("R3 R8 smull m128", 3'b110, 32'd77, 32'hffffff80, 32'h0, 32'h0);
        issue("R3 R8 smull m129", 3'b110, 32'd77, 32'hffffff7f, 32'h0, 32'h0);
        issue("R3 R8 smull 3 slices", 3'b110, 32'h80000000, 32'hff80_1234, 32'h0, 32'h0);
        issue("R3 R8 smull minneg", 3'b110, 32'h80000000, 32'h80000000, 32'h0, 32'h0);
        issue("R3 smlal neg acc", 3'b111, 32'hffff0000, 32'h00012345, 32'hffffffff, 32'hfffffff0);
        issue("R3 smlal pos", 3'b111, 32'h7fffffff, 32'h7fffffff, 32'h1, 32'h2);
        drain();

        // R5 start held while busy (4-slice operation)
        issue("R5 first op kept", 3'b100, 32'h01020304, 32'hf0000000, 32'h0, 32'h0);
        start = 1'b1; op = 3'b111; opa = 32'h55; opb = 32'h66; acc_hi = 32'h7; acc_lo = 32'h8;
        repeat (2) @(negedge clk);
        start = 1'b0;
        drain();
        repeat (4) @(negedge clk);
        // R6 result held after done
        check("R6 hold", {res_hi, res_lo}, last_val);
        check("R5 idle after ignored start", {63'd0, busy}, 64'd0);

        // R4 back-to-back: next start accepted in the done cycle
        issue("R4 b2b first", 3'b000, 32'd3, 32'd5, 32'h0, 32'h0);
        issue("R4 b2b second", 3'b101, 32'd9, 32'h00010000, 32'd1, 32'd2);
        drain();
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule